// File: doc/BRIEF.md
# External I/O Bus Gateway

The gateway sits between the processor's port-mapped I/O cycles and an external expansion connector. It copies the port address and write data onto the connector, forms separate input and output strobes, and passes the opcode-fetch and I/O-request lines through so that a device on the connector can recognise an interrupt acknowledge. None of these lines is driven unless software has set an enable bit in a control port. Only reset reaches the connector at all times.

The gateway also sets the direction of the data transceiver. It turns the transceiver toward the processor only when a device claims an input cycle through its select line. It passes the device's wait request to the processor only while external I/O is enabled. It passes the device's interrupt to the processor only while a separate mask bit allows it. Software can always read the raw interrupt level from a status port.

Port numbers 80h and above belong to the system. They never appear on the connector as input or output accesses. Every output is registered, so it follows its inputs by one clock.

Top module: `ext_io_gateway`

## Requirements
- R1: A synchronous active-high `rst` clears both enable bits. While `rst` is high, every output is 0 except `ext_reset`, which is 1. One clock after `rst` falls, `ext_reset` is 0.
- R2: While the external enable (bit 4 of control port ECh) is 0, the following outputs are all 0: `bus_drive_en`, `ext_addr`, `ext_wdata`, `ext_in`, `ext_out`, `ext_iorq`, `ext_m1` and `xcvr_to_cpu`.
- R3: With the external enable set, and one clock after each cycle, the gateway drives the following:
  - `bus_drive_en` = 1, with the sampled address on `ext_addr` and the sampled write data on `ext_wdata`.
  - `ext_in` = `cpu_iorq & cpu_rd & ~cpu_m1` for ports 00h-7Fh.
  - `ext_out` = `cpu_iorq & cpu_wr & ~cpu_m1` for ports 00h-7Fh.
  - `ext_iorq` = 1 for an I/O request to ports 00h-7Fh.
- R4: For port numbers 80h-FFh, `ext_in`, `ext_out` and `ext_iorq` stay 0 when `cpu_m1` is 0.
- R5: When `cpu_m1` and `cpu_iorq` are both high with the enable set, the next clock gives `ext_m1` = 1, `ext_iorq` = 1, `ext_in` = 0, `ext_out` = 0 and `xcvr_to_cpu` = 0, whatever the address.
- R6: `cpu_int` is `ext_int` sampled one clock earlier, gated by the interrupt mask bit. The mask bit is bit 0 of port E0h on write, and 1 enables.
- R7: A read of port E0h returns the sampled `ext_int` level in bit 3 and the mask bit in bit 0, with all other bits 0. This holds whether the mask bit is set or not.
- R8: `cpu_wait` is `ext_wait` sampled one clock earlier, and only while the external enable is 1.
- R9: `xcvr_to_cpu` is 1 exactly when `ext_in` is 1 and `ext_sel` was high in the same sampled cycle. In that case `cpu_rdata` returns `ext_rdata`. Any other read of a port below 80h returns 0.
- R10: A write to ECh stores only bit 4, and a write to E0h stores only bit 0. A read of ECh returns the stored byte, and a read of any other reserved port returns 0. Writes with `cpu_m1` high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 8 | Processor port address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_iorq | input | 1 | I/O request, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_m1 | input | 1 | Opcode fetch / acknowledge marker, active high |
| cpu_rdata | output | 8 | Read data returned to the processor |
| cpu_wait | output | 1 | Wait request to the processor |
| cpu_int | output | 1 | Interrupt request to the processor |
| ext_int | input | 1 | Interrupt line from the connector |
| ext_wait | input | 1 | Wait line from the connector |
| ext_sel | input | 1 | Device claims the current input cycle |
| ext_rdata | input | 8 | Data from the connector transceiver |
| bus_drive_en | output | 1 | Output enable for the connector drivers |
| ext_addr | output | 8 | Connector address |
| ext_wdata | output | 8 | Connector write data |
| ext_in | output | 1 | Connector input strobe |
| ext_out | output | 1 | Connector output strobe |
| ext_m1 | output | 1 | Connector opcode fetch marker |
| ext_iorq | output | 1 | Connector I/O request |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward processor |
| ext_reset | output | 1 | Connector reset |

## Verification
The bench sweeps all 256 port numbers twice, once with the enable clear and once with it set. Each port is tried as a read and as a write, each with the select line low and high. This separates three behaviours: the quiet connector, the forwarded user ports, and the reserved ports that must stay off the connector. The select line separates a transceiver turn-around from an ordinary forwarded read.

The interrupt line is tried against both mask states, and the wait line against both enable states. Each raw interrupt level is read back through E0h, so masking and status visibility are told apart. Three further patterns are applied:
- An acknowledge cycle with select asserted, at a user port and at a reserved port. This shows whether the direction logic respects the acknowledge.
- Control writes with every non-enable bit set, to confirm that only the enable bit is stored.
- A reset taken in the middle of the run, to confirm that both enable bits clear.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int GW_ADDR_W      = 8;
  localparam int GW_DATA_W      = 8;
  localparam int GW_RESV_BASE   = 'h80;
  localparam int GW_CTRL_PORT   = 'hEC;
  localparam int GW_MASK_PORT   = 'hE0;
  localparam int GW_EXIO_BIT    = 4;
  localparam int GW_IE_BIT      = 0;
  localparam int GW_STAT_BIT    = 3;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CTRL  = 2'd1,
    RD_MASK  = 2'd2,
    RD_EXT   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/gw_ctrl_regs.sv
module gw_ctrl_regs #(
  parameter int ADDR_W    = gw_pkg::GW_ADDR_W,
  parameter int DATA_W    = gw_pkg::GW_DATA_W,
  parameter int RESV_BASE = gw_pkg::GW_RESV_BASE,
  parameter int CTRL_PORT = gw_pkg::GW_CTRL_PORT,
  parameter int MASK_PORT = gw_pkg::GW_MASK_PORT,
  parameter int EXIO_BIT  = gw_pkg::GW_EXIO_BIT,
  parameter int IE_BIT    = gw_pkg::GW_IE_BIT,
  parameter int STAT_BIT  = gw_pkg::GW_STAT_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iorq,
  input  logic              rd,
  input  logic              wr,
  input  logic              m1,
  input  logic              ext_int,
  input  logic              ext_sel,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              exio_en,
  output logic              int_en,
  output logic [DATA_W-1:0] rdata
);
  import gw_pkg::*;

  localparam logic [DATA_W-1:0] EXIO_MASK = DATA_W'(1) << EXIO_BIT;
  localparam logic [DATA_W-1:0] IE_MASK   = DATA_W'(1) << IE_BIT;
  localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_PORT);
  localparam logic [ADDR_W-1:0] MASK_A    = ADDR_W'(MASK_PORT);
  localparam logic [ADDR_W-1:0] RESV_A    = ADDR_W'(RESV_BASE);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] mask_q;
  logic              io_write;
  logic              io_read;
  logic              user_port;
  rd_src_e           rd_src;
  logic [DATA_W-1:0] rd_next;

  assign io_write  = iorq & wr & ~m1;
  assign io_read   = iorq & rd & ~m1;
  assign user_port = (addr < RESV_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (io_write) begin
      if (addr == CTRL_A) ctrl_q <= wdata & EXIO_MASK;
      if (addr == MASK_A) mask_q <= wdata & IE_MASK;
    end
  end

  assign exio_en = ctrl_q[EXIO_BIT];
  assign int_en  = mask_q[IE_BIT];

  always_comb begin
    rd_src = RD_NONE;
    if (io_read) begin
      if (addr == CTRL_A)                       rd_src = RD_CTRL;
      else if (addr == MASK_A)                  rd_src = RD_MASK;
      else if (user_port && exio_en && ext_sel) rd_src = RD_EXT;
    end
  end

  always_comb begin
    unique case (rd_src)
      RD_CTRL: rd_next = ctrl_q;
      RD_MASK: begin
        rd_next           = mask_q;
        rd_next[STAT_BIT] = ext_int;
      end
      RD_EXT:  rd_next = ext_rdata;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/gw_bus_drive.sv
module gw_bus_drive #(
  parameter int ADDR_W    = gw_pkg::GW_ADDR_W,
  parameter int DATA_W    = gw_pkg::GW_DATA_W,
  parameter int RESV_BASE = gw_pkg::GW_RESV_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exio_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iorq,
  input  logic              rd,
  input  logic              wr,
  input  logic              m1,
  input  logic              ext_sel,
  output logic              bus_drive_en,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_in,
  output logic              ext_out,
  output logic              ext_m1,
  output logic              ext_iorq,
  output logic              xcvr_to_cpu,
  output logic              ext_reset
);
  localparam logic [ADDR_W-1:0] RESV_A = ADDR_W'(RESV_BASE);

  logic user_port;
  logic in_next;
  logic out_next;
  logic ack_next;
  logic iorq_next;

  assign user_port = (addr < RESV_A);
  assign in_next   = exio_en & iorq & rd & ~m1 & user_port;
  assign out_next  = exio_en & iorq & wr & ~m1 & user_port;
  assign ack_next  = exio_en & iorq & m1;
  assign iorq_next = ack_next | (exio_en & iorq & user_port);

  always_ff @(posedge clk) begin
    ext_reset <= rst;
    if (rst) begin
      bus_drive_en <= 1'b0;
      ext_addr     <= '0;
      ext_wdata    <= '0;
      ext_in       <= 1'b0;
      ext_out      <= 1'b0;
      ext_m1       <= 1'b0;
      ext_iorq     <= 1'b0;
      xcvr_to_cpu  <= 1'b0;
    end else begin
      bus_drive_en <= exio_en;
      ext_addr     <= exio_en ? addr  : '0;
      ext_wdata    <= exio_en ? wdata : '0;
      ext_in       <= in_next;
      ext_out      <= out_next;
      ext_m1       <= exio_en & m1;
      ext_iorq     <= iorq_next;
      xcvr_to_cpu  <= in_next & ext_sel;
    end
  end
endmodule

// File: rtl/gw_cpu_lines.sv
module gw_cpu_lines (
  input  logic clk,
  input  logic rst,
  input  logic exio_en,
  input  logic int_en,
  input  logic ext_wait,
  input  logic ext_int,
  output logic cpu_wait,
  output logic cpu_int
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_wait <= 1'b0;
      cpu_int  <= 1'b0;
    end else begin
      cpu_wait <= exio_en & ext_wait;
      cpu_int  <= int_en & ext_int;
    end
  end
endmodule

// File: rtl/ext_io_gateway.sv
module ext_io_gateway #(
  parameter int ADDR_W    = gw_pkg::GW_ADDR_W,
  parameter int DATA_W    = gw_pkg::GW_DATA_W,
  parameter int RESV_BASE = gw_pkg::GW_RESV_BASE,
  parameter int CTRL_PORT = gw_pkg::GW_CTRL_PORT,
  parameter int MASK_PORT = gw_pkg::GW_MASK_PORT,
  parameter int EXIO_BIT  = gw_pkg::GW_EXIO_BIT,
  parameter int IE_BIT    = gw_pkg::GW_IE_BIT,
  parameter int STAT_BIT  = gw_pkg::GW_STAT_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_iorq,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_m1,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_wait,
  output logic              cpu_int,
  input  logic              ext_int,
  input  logic              ext_wait,
  input  logic              ext_sel,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              bus_drive_en,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_in,
  output logic              ext_out,
  output logic              ext_m1,
  output logic              ext_iorq,
  output logic              xcvr_to_cpu,
  output logic              ext_reset
);
  logic exio_en;
  logic int_en;

  gw_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESV_BASE(RESV_BASE),
    .CTRL_PORT(CTRL_PORT), .MASK_PORT(MASK_PORT),
    .EXIO_BIT(EXIO_BIT), .IE_BIT(IE_BIT), .STAT_BIT(STAT_BIT)
  ) regs_i (
    .clk(clk), .rst(rst),
    .addr(cpu_addr), .wdata(cpu_wdata),
    .iorq(cpu_iorq), .rd(cpu_rd), .wr(cpu_wr), .m1(cpu_m1),
    .ext_int(ext_int), .ext_sel(ext_sel), .ext_rdata(ext_rdata),
    .exio_en(exio_en), .int_en(int_en), .rdata(cpu_rdata)
  );

  gw_bus_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESV_BASE(RESV_BASE)
  ) drive_i (
    .clk(clk), .rst(rst), .exio_en(exio_en),
    .addr(cpu_addr), .wdata(cpu_wdata),
    .iorq(cpu_iorq), .rd(cpu_rd), .wr(cpu_wr), .m1(cpu_m1),
    .ext_sel(ext_sel),
    .bus_drive_en(bus_drive_en), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_in(ext_in), .ext_out(ext_out), .ext_m1(ext_m1), .ext_iorq(ext_iorq),
    .xcvr_to_cpu(xcvr_to_cpu), .ext_reset(ext_reset)
  );

  gw_cpu_lines lines_i (
    .clk(clk), .rst(rst), .exio_en(exio_en), .int_en(int_en),
    .ext_wait(ext_wait), .ext_int(ext_int),
    .cpu_wait(cpu_wait), .cpu_int(cpu_int)
  );
endmodule

// File: rtl/gw_checker.sv
module gw_checker #(
  parameter int ADDR_W    = 8,
  parameter int RESV_BASE = 'h80
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_iorq,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              cpu_m1,
  input logic              ext_int,
  input logic              ext_wait,
  input logic              ext_sel,
  input logic              cpu_wait,
  input logic              cpu_int,
  input logic              bus_drive_en,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_in,
  input logic              ext_out,
  input logic              ext_m1,
  input logic              ext_iorq,
  input logic              xcvr_to_cpu
);
  localparam logic [ADDR_W-1:0] RESV_A = ADDR_W'(RESV_BASE);

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !bus_drive_en |-> (!ext_in && !ext_out && !ext_iorq && !ext_m1 && ext_addr == '0));

  a_r3_in_strobe: assert property (@(posedge clk) disable iff (rst)
    ext_in |-> ($past(cpu_iorq) && $past(cpu_rd) && !$past(cpu_m1)));

  a_r3_out_strobe: assert property (@(posedge clk) disable iff (rst)
    ext_out |-> ($past(cpu_iorq) && $past(cpu_wr) && !$past(cpu_m1)));

  a_r4_no_reserved: assert property (@(posedge clk) disable iff (rst)
    (ext_in || ext_out) |-> ($past(cpu_addr) < RESV_A));

  a_r5_ack_passes: assert property (@(posedge clk) disable iff (rst)
    (bus_drive_en && $past(cpu_m1) && $past(cpu_iorq)) |-> (ext_m1 && ext_iorq && !xcvr_to_cpu));

  a_r6_int_source: assert property (@(posedge clk) disable iff (rst)
    cpu_int |-> $past(ext_int));

  a_r8_wait_gated: assert property (@(posedge clk) disable iff (rst)
    cpu_wait |-> ($past(ext_wait) && bus_drive_en));

  a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
    xcvr_to_cpu |-> (ext_in && $past(ext_sel)));
endmodule

bind ext_io_gateway gw_checker #(.ADDR_W(ADDR_W), .RESV_BASE(RESV_BASE)) chk_i (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_iorq(cpu_iorq),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_m1(cpu_m1),
  .ext_int(ext_int), .ext_wait(ext_wait), .ext_sel(ext_sel),
  .cpu_wait(cpu_wait), .cpu_int(cpu_int), .bus_drive_en(bus_drive_en),
  .ext_addr(ext_addr), .ext_in(ext_in), .ext_out(ext_out),
  .ext_m1(ext_m1), .ext_iorq(ext_iorq), .xcvr_to_cpu(xcvr_to_cpu)
);

// File: tb/ext_io_gateway_tb_top.sv
module ext_io_gateway_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] cpu_addr, cpu_wdata, ext_rdata;
  logic       cpu_iorq, cpu_rd, cpu_wr, cpu_m1, ext_int, ext_wait, ext_sel;
  logic [7:0] cpu_rdata, ext_addr, ext_wdata;
  logic       cpu_wait, cpu_int, bus_drive_en, ext_in, ext_out, ext_m1, ext_iorq;
  logic       xcvr_to_cpu, ext_reset;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_io_gateway dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_iorq(cpu_iorq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_m1(cpu_m1),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .cpu_int(cpu_int),
    .ext_int(ext_int), .ext_wait(ext_wait), .ext_sel(ext_sel), .ext_rdata(ext_rdata),
    .bus_drive_en(bus_drive_en), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_in(ext_in), .ext_out(ext_out), .ext_m1(ext_m1), .ext_iorq(ext_iorq),
    .xcvr_to_cpu(xcvr_to_cpu), .ext_reset(ext_reset)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_addr = 8'h00; cpu_wdata = 8'h00; cpu_iorq = 1'b0; cpu_rd = 1'b0;
    cpu_wr = 1'b0; cpu_m1 = 1'b0; ext_sel = 1'b0; ext_rdata = 8'h00;
  endtask

  // apply inputs at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cycle_io(logic [7:0] a, logic [7:0] d, logic iq, logic r, logic w,
                          logic m, logic s);
    cpu_addr = a; cpu_wdata = d; cpu_iorq = iq; cpu_rd = r; cpu_wr = w;
    cpu_m1 = m; ext_sel = s; ext_rdata = ~a;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic wr_port(logic [7:0] a, logic [7:0] d);
    cycle_io(a, d, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic rd_port(logic [7:0] a);
    cycle_io(a, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; ext_int = 1'b0; ext_wait = 1'b0;
    idle();
    @(negedge clk);
    // R1: activity during reset is ignored
    cpu_iorq = 1'b1; cpu_rd = 1'b1; cpu_addr = 8'h10; ext_sel = 1'b1;
    ext_int = 1'b1; ext_wait = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 outputs in reset", {bus_drive_en, ext_in, ext_out, ext_iorq, ext_m1,
          xcvr_to_cpu, cpu_wait, cpu_int, cpu_rdata}, 32'h0);
    check("R1 ext_reset high", ext_reset, 1);
    idle(); ext_int = 1'b0; ext_wait = 1'b0;
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 ext_reset released", ext_reset, 0);
    rd_port(8'hEC);
    check("R1 control cleared", cpu_rdata, 0);
    rd_port(8'hE0);
    check("R1 mask cleared", cpu_rdata, 0);

    // R10: only the enable bit is stored
    wr_port(8'hEC, 8'hEF);
    rd_port(8'hEC);
    check("R10 control keeps bit4 only", cpu_rdata, 0);
    check("R10 still off", bus_drive_en, 0);
    cycle_io(8'hEC, 8'h10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    rd_port(8'hEC);
    check("R10 write with m1 ignored", cpu_rdata, 0);
    wr_port(8'hE0, 8'hFE);
    rd_port(8'hE0);
    check("R10 mask keeps bit0 only", cpu_rdata, 0);
    rd_port(8'hC5);
    check("R10 other reserved read", cpu_rdata, 0);

    // R2/R3/R4/R9 sweep
    for (int en = 0; en < 2; en++) begin
      wr_port(8'hEC, en ? 8'h10 : 8'h00);
      rd_port(8'hEC);
      check("R10 control readback", cpu_rdata, en ? 32'h10 : 32'h0);
      for (int ai = 0; ai < 256; ai++) begin
        for (int k = 0; k < 2; k++) begin
          for (int s = 0; s < 2; s++) begin
            logic [7:0] a = 8'(ai);
            logic [7:0] d = a ^ 8'h5A;
            bit usr = (ai < 128);
            bit e_in, e_out, e_iorq, e_dir;
            logic [7:0] e_rd;
            string tag;
            if (k == 1 && (a == 8'hEC || a == 8'hE0)) continue;
            e_in   = en && k == 0 && usr;
            e_out  = en && k == 1 && usr;
            e_iorq = en && usr;
            e_dir  = e_in && s == 1;
            if (k == 1)            e_rd = 8'h00;
            else if (a == 8'hEC)   e_rd = en ? 8'h10 : 8'h00;
            else if (a == 8'hE0)   e_rd = 8'h00;
            else if (e_dir)        e_rd = ~a;
            else                   e_rd = 8'h00;
            cycle_io(a, d, 1'b1, k == 0, k == 1, 1'b0, s[0]);
            tag = !en ? "R2 bus quiet" : (usr ? "R3 forwarded cycle" : "R4 reserved port");
            check(tag, {bus_drive_en, ext_addr, ext_wdata, ext_in, ext_out, ext_iorq, ext_m1},
                  {8'h0, 1'(en), en ? a : 8'h00, en ? d : 8'h00, 1'(e_in), 1'(e_out),
                   1'(e_iorq), 1'b0});
            check("R9 direction and read data", {xcvr_to_cpu, cpu_rdata}, {1'(e_dir), e_rd});
          end
        end
      end
    end

    // R5: interrupt acknowledge with select asserted
    cycle_io(8'h10, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R5 ack user port", {ext_m1, ext_iorq, ext_in, ext_out, xcvr_to_cpu}, 5'b11000);
    cycle_io(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R5 ack reserved port", {ext_m1, ext_iorq, ext_in, ext_out, xcvr_to_cpu}, 5'b11000);

    // R8: wait gating
    for (int en = 0; en < 2; en++) begin
      wr_port(8'hEC, en ? 8'h10 : 8'h00);
      for (int w = 0; w < 2; w++) begin
        ext_wait = w[0];
        @(posedge clk); @(negedge clk);
        check("R8 wait gating", cpu_wait, en & w);
      end
      ext_wait = 1'b0;
    end

    // R6/R7: interrupt mask and raw status
    for (int ie = 0; ie < 2; ie++) begin
      wr_port(8'hE0, ie ? 8'h01 : 8'h00);
      for (int ei = 0; ei < 2; ei++) begin
        ext_int = ei[0];
        @(posedge clk); @(negedge clk);
        check("R6 interrupt gating", cpu_int, ie & ei);
        rd_port(8'hE0);
        check("R7 raw status read", cpu_rdata, (ei << 3) | ie);
      end
      ext_int = 1'b0;
    end

    // R1: reset in mid-run clears both enables
    wr_port(8'hEC, 8'h10);
    wr_port(8'hE0, 8'h01);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    rd_port(8'hEC);
    check("R1 control after mid reset", cpu_rdata, 0);
    rd_port(8'hE0);
    check("R1 mask after mid reset", cpu_rdata, 0);
    check("R1 drive off after mid reset", bus_drive_en, 0);

    done = 1'b1;
    summary();
  end
endmodule